// File: doc/BRIEF.md
# Degrade/Failure Defect Clearance Monitor

This block decides when a signal-degrade (SD) condition and a signal-fail (SF) condition on a SONET STS-1/STS-3 receive path may be cleared. While a condition is raised, its monitor counts line parity (B2, BIP-24) errors reported frame by frame. It also counts 1 ms ticks, so each window lasts a programmed number of milliseconds. When a window completes, the monitor compares the error total with a clear threshold. It issues a one-cycle clear pulse only when the total is strictly below that threshold.

The SD monitor and the SF monitor run side by side. Each has its own 24-bit window length and its own 16-bit threshold. Both are set through a byte-wide write port. The parity computation, the framing and the logic that raises the conditions in the first place sit outside this block. The surrounding defect logic drops its condition flag when it sees the clear pulse.

Top module: `dcm_top`

## Requirements
- R1: Window lengths are 24-bit millisecond counts, each held in three byte registers. The SD window is at addresses 0 (bits 7:0), 1 (bits 15:8) and 2 (bits 23:16). The SF window is at addresses 3, 4 and 5 in the same byte order. Every window byte resets to 0xFF, so the default window is 0xFFFFFF ms.
- R2: Clear thresholds are 16-bit unsigned values, each held in two byte registers. The SD threshold is at address 6 (low byte) and address 7 (high byte). The SF threshold is at address 8 (low byte) and address 9 (high byte). Both thresholds reset to 0, so a threshold left at its reset value never clears a condition.
- R3: While a condition is raised, each cycle with `frame_stb` high adds `frame_err` to that monitor's total. A window of N ms ends on the Nth `tick_1ms` counted from the start of the window. The tick count and the error total then restart for the next window.
- R4: When a window ends, the clear output pulses in the cycle after the ending tick, but only if the window total (including any frame in the ending cycle) is strictly below the threshold. A total equal to the threshold gives no pulse.
- R5: A monitor evaluates only while its condition flag is high. Dropping the flag abandons the current window. Raising the flag starts a fresh window, with the tick count and error total at zero.
- R6: The error total saturates at 0xFFFF instead of wrapping.
- R7: A window length of zero acts as a length of 1 ms.
- R8: A window length written during a window takes effect from the next window. The current window keeps the length it started with.
- R9: The SD and SF monitors are independent. Each uses only its own flag, window and threshold.
- R10: Each clear pulse lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register byte address |
| cfg_wdata | input | 8 | Register write data |
| frame_stb | input | 1 | One cycle per received frame |
| frame_err | input | 5 | Parity errors in that frame, valid with `frame_stb` |
| tick_1ms | input | 1 | One-cycle millisecond tick |
| sd_active | input | 1 | SD condition currently raised |
| sf_active | input | 1 | SF condition currently raised |
| sd_clear | output | 1 | One-cycle pulse: SD may be cleared |
| sf_clear | output | 1 | One-cycle pulse: SF may be cleared |

## Verification
A wrong tick count or a wrong latched window length moves the clear pulse to a different tick. The bench checks the clear outputs on every tick, so such a fault shows on the first window that should, or should not, end. A wrong error total or a wrong compare shows at the first window end, for example as a pulse on a total equal to the threshold, or as a pulse after the accumulator wrapped. A window that fails to restart when the flag rises shows within the first window after re-arming.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
  localparam int BYTE_W  = 8;
  localparam int NUM_DEF = 2;
  localparam int CH_SD   = 0;
  localparam int CH_SF   = 1;
endpackage

// File: rtl/dcm_rst_sync.sv
module dcm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dcm_cfg_regs.sv
module dcm_cfg_regs
  import dcm_pkg::*;
#(
  parameter int WIN_BYTES = 3,
  parameter int THR_BYTES = 2,
  parameter int ADDR_W    = 4,
  localparam int WIN_W    = WIN_BYTES * BYTE_W,
  localparam int THR_W    = THR_BYTES * BYTE_W,
  localparam int NREG     = 2 * WIN_BYTES + 2 * THR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [WIN_W-1:0]  sd_len_o,
  output logic [WIN_W-1:0]  sf_len_o,
  output logic [THR_W-1:0]  sd_thr_o,
  output logic [THR_W-1:0]  sf_thr_o
);
  logic [NREG-1:0][BYTE_W-1:0] reg_q;
  logic [NREG-1:0][BYTE_W-1:0] reg_d;

  function automatic logic [BYTE_W-1:0] rst_val(input int idx);
    return (idx < 2 * WIN_BYTES) ? {BYTE_W{1'b1}} : '0;
  endfunction

  always_comb begin
    reg_d = reg_q;
    for (int i = 0; i < NREG; i++) begin
      if (wr_i && (addr_i == ADDR_W'(i))) reg_d[i] = wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) reg_q[i] <= rst_val(i);
    end else if (wr_i) begin
      reg_q <= reg_d;
    end
  end

  assign sd_len_o = reg_q[WIN_BYTES-1:0];
  assign sf_len_o = reg_q[2*WIN_BYTES-1:WIN_BYTES];
  assign sd_thr_o = reg_q[2*WIN_BYTES+THR_BYTES-1:2*WIN_BYTES];
  assign sf_thr_o = reg_q[NREG-1:2*WIN_BYTES+THR_BYTES];
endmodule

// File: rtl/dcm_window.sv
module dcm_window #(
  parameter int WIN_W = 24,
  parameter int CNT_W = 16,
  parameter int ERR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  input  logic             tick_i,
  input  logic             frame_stb_i,
  input  logic [ERR_W-1:0] frame_err_i,
  input  logic [WIN_W-1:0] len_cfg_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             clear_o
);
  logic             act_q, act_d;
  logic [WIN_W-1:0] ms_q, ms_d, len_q, len_d, len_eff;
  logic [CNT_W-1:0] acc_q, acc_d, acc_sum;
  logic [CNT_W:0]   acc_wide;
  logic             clr_q, clr_d;
  logic             start, run, wend, state_en;

  always_comb begin
    start    = active_i & ~act_q;
    run      = active_i & act_q;
    acc_wide = {1'b0, acc_q} + (CNT_W+1)'(frame_err_i);
    if (!frame_stb_i)        acc_sum = acc_q;
    else if (acc_wide[CNT_W]) acc_sum = '1;
    else                      acc_sum = acc_wide[CNT_W-1:0];
    wend     = run & tick_i & (ms_q == (len_q - 1'b1));
    len_eff  = (len_cfg_i == '0) ? WIN_W'(1) : len_cfg_i;
    state_en = start | run;

    act_d = active_i;
    ms_d  = ms_q;
    len_d = len_q;
    acc_d = acc_q;
    clr_d = 1'b0;
    if (start) begin
      ms_d  = '0;
      acc_d = '0;
      len_d = len_eff;
    end else if (wend) begin
      ms_d  = '0;
      acc_d = '0;
      len_d = len_eff;
      clr_d = (acc_sum < thr_i);
    end else if (run) begin
      acc_d = acc_sum;
      if (tick_i) ms_d = ms_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      act_q <= act_d;
      clr_q <= clr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms_q  <= '0;
      len_q <= '1;
      acc_q <= '0;
    end else if (state_en) begin
      ms_q  <= ms_d;
      len_q <= len_d;
      acc_q <= acc_d;
    end
  end

  assign clear_o = clr_q;

  // R4: a clear pulse follows a millisecond tick
  a_r4_clear_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    clear_o |-> $past(tick_i));
  // R5: a clear pulse needs the condition raised in the evaluating cycle
  a_r5_clear_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    clear_o |-> $past(active_i));
  // R6: inside a window the total never falls (saturates, no wrap)
  a_r6_acc_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wend) |=> (acc_q >= $past(acc_q)));
  // R8: latched length changes only at a window boundary
  a_r8_len_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !wend) |=> $stable(len_q));
  // R7: tick count always stays below a nonzero window length
  a_r7_ms_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q != '0) && (ms_q < len_q));
endmodule

// File: rtl/dcm_top.sv
module dcm_top
  import dcm_pkg::*;
#(
  parameter int WIN_BYTES = 3,
  parameter int THR_BYTES = 2,
  parameter int ERR_W     = 5,
  parameter int ADDR_W    = 4,
  localparam int WIN_W    = WIN_BYTES * BYTE_W,
  localparam int THR_W    = THR_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [BYTE_W-1:0] cfg_wdata,
  input  logic              frame_stb,
  input  logic [ERR_W-1:0]  frame_err,
  input  logic              tick_1ms,
  input  logic              sd_active,
  input  logic              sf_active,
  output logic              sd_clear,
  output logic              sf_clear
);
  logic             rst_core_n;
  logic [WIN_W-1:0] sd_len, sf_len;
  logic [THR_W-1:0] sd_thr, sf_thr;
  logic [NUM_DEF-1:0]             flag_vec, clr_vec;
  logic [NUM_DEF-1:0][WIN_W-1:0]  len_vec;
  logic [NUM_DEF-1:0][THR_W-1:0]  thr_vec;

  dcm_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_core_n)
  );

  dcm_cfg_regs #(
    .WIN_BYTES(WIN_BYTES), .THR_BYTES(THR_BYTES), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_core_n), .wr_i(cfg_wr), .addr_i(cfg_addr),
    .wdata_i(cfg_wdata), .sd_len_o(sd_len), .sf_len_o(sf_len),
    .sd_thr_o(sd_thr), .sf_thr_o(sf_thr)
  );

  assign flag_vec[CH_SD] = sd_active;
  assign flag_vec[CH_SF] = sf_active;
  assign len_vec[CH_SD]  = sd_len;
  assign len_vec[CH_SF]  = sf_len;
  assign thr_vec[CH_SD]  = sd_thr;
  assign thr_vec[CH_SF]  = sf_thr;

  for (genvar c = 0; c < NUM_DEF; c++) begin : g_mon
    dcm_window #(.WIN_W(WIN_W), .CNT_W(THR_W), .ERR_W(ERR_W)) u_win (
      .clk(clk), .rst_n(rst_core_n), .active_i(flag_vec[c]),
      .tick_i(tick_1ms), .frame_stb_i(frame_stb), .frame_err_i(frame_err),
      .len_cfg_i(len_vec[c]), .thr_i(thr_vec[c]), .clear_o(clr_vec[c])
    );
  end

  assign sd_clear = clr_vec[CH_SD];
  assign sf_clear = clr_vec[CH_SF];
endmodule

// File: tb/dcm_top_tb.sv
module dcm_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       frame_stb = 1'b0;
  logic [4:0] frame_err = '0;
  logic       tick_1ms = 1'b0;
  logic       sd_active = 1'b0;
  logic       sf_active = 1'b0;
  logic       sd_clear, sf_clear;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dcm_top u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .frame_stb(frame_stb), .frame_err(frame_err),
    .tick_1ms(tick_1ms), .sd_active(sd_active), .sf_active(sf_active),
    .sd_clear(sd_clear), .sf_clear(sf_clear)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 100000", cyc);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic set_win(input bit sf, input logic [23:0] v);
    logic [3:0] base;
    base = sf ? 4'd3 : 4'd0;
    wr(base, v[7:0]); wr(base + 4'd1, v[15:8]); wr(base + 4'd2, v[23:16]);
  endtask

  task automatic set_thr(input bit sf, input logic [15:0] v);
    logic [3:0] base;
    base = sf ? 4'd8 : 4'd6;
    wr(base, v[7:0]); wr(base + 4'd1, v[15:8]);
  endtask

  task automatic frame(input logic [4:0] e);
    frame_stb = 1'b1; frame_err = e;
    @(negedge clk);
    frame_stb = 1'b0; frame_err = '0;
  endtask

  // one tick; returns the clear outputs of the following cycle; R10 width check
  task automatic tick(output logic sd_o, output logic sf_o);
    tick_1ms = 1'b1;
    @(negedge clk);
    tick_1ms = 1'b0;
    sd_o = sd_clear; sf_o = sf_clear;
    @(negedge clk);
    chk(!sd_clear && !sf_clear, "R10 pulse width", int'({sd_clear, sf_clear}), 0);
  endtask

  task automatic arm(input bit sd, input bit sf);
    sd_active = sd; sf_active = sf;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic s, f;
    chk(!sd_clear && !sf_clear, "R1 reset outputs", int'({sd_clear, sf_clear}), 0);
    set_thr(1'b0, 16'd100);
    arm(1'b1, 1'b0);
    for (int i = 0; i < 8; i++) begin
      tick(s, f);
      chk(!s, "R1 default window long", int'(s), 0);
    end
    arm(1'b0, 1'b0);
    set_win(1'b1, 24'd1);
    arm(1'b0, 1'b1);
    tick(s, f);
    chk(!f, "R2 default threshold zero", int'(f), 0);
    set_thr(1'b1, 16'd1);
    tick(s, f);
    chk(f, "R2 threshold bytes", int'(f), 1);
    arm(1'b0, 1'b0);
  endtask

  task automatic t_basic();
    logic s, f;
    set_win(1'b0, 24'd3);
    set_thr(1'b0, 16'd5);
    arm(1'b1, 1'b0);
    frame(5'd4);
    tick(s, f); chk(!s, "R3 tick 1 of 3", int'(s), 0);
    tick(s, f); chk(!s, "R3 tick 2 of 3", int'(s), 0);
    tick(s, f); chk(s, "R4 below threshold clears", int'(s), 1);
    frame(5'd3); frame(5'd2);
    tick(s, f); tick(s, f);
    chk(!s, "R3 second window mid", int'(s), 0);
    tick(s, f); chk(!s, "R4 equal does not clear", int'(s), 0);
    frame(5'd4);
    tick(s, f); tick(s, f); tick(s, f);
    chk(s, "R3 total restarts per window", int'(s), 1);
  endtask

  task automatic t_flag();
    logic s, f;
    frame(5'd9);
    tick(s, f); tick(s, f);
    arm(1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      frame(5'd0);
      tick(s, f);
      chk(!s, "R5 no clear while flag low", int'(s), 0);
    end
    arm(1'b1, 1'b0);
    tick(s, f); chk(!s, "R5 fresh window tick 1", int'(s), 0);
    tick(s, f); chk(!s, "R5 fresh window tick 2", int'(s), 0);
    tick(s, f); chk(s, "R5 fresh window clears", int'(s), 1);
  endtask

  task automatic t_zero();
    logic s, f;
    arm(1'b0, 1'b0);
    set_win(1'b0, 24'd0);
    arm(1'b1, 1'b0);
    tick(s, f); chk(s, "R7 zero length one tick", int'(s), 1);
    tick(s, f); chk(s, "R7 zero length repeat", int'(s), 1);
  endtask

  task automatic t_midwrite();
    logic s, f;
    arm(1'b0, 1'b0);
    set_win(1'b0, 24'd3);
    arm(1'b1, 1'b0);
    tick(s, f); chk(!s, "R8 tick 1", int'(s), 0);
    set_win(1'b0, 24'd1);
    tick(s, f); chk(!s, "R8 old length kept", int'(s), 0);
    tick(s, f); chk(s, "R8 old window ends", int'(s), 1);
    tick(s, f); chk(s, "R8 new length used", int'(s), 1);
  endtask

  task automatic t_sat();
    logic s, f;
    arm(1'b0, 1'b0);
    set_thr(1'b0, 16'hFFFF);
    arm(1'b1, 1'b0);
    for (int i = 0; i < 2200; i++) frame(5'd31);
    tick(s, f); chk(!s, "R6 saturated total not below max", int'(s), 0);
    frame(5'd31);
    tick(s, f); chk(s, "R6 small total clears", int'(s), 1);
  endtask

  task automatic t_indep();
    logic s, f;
    arm(1'b0, 1'b0);
    set_win(1'b0, 24'd5); set_thr(1'b0, 16'd1);
    set_win(1'b1, 24'd2); set_thr(1'b1, 16'd3);
    arm(1'b1, 1'b1);
    frame(5'd2);
    tick(s, f); chk(!s && !f, "R9 tick 1", int'({s, f}), 0);
    tick(s, f); chk(!s && f, "R9 SF clears alone", int'({s, f}), 1);
    arm(1'b1, 1'b0);
    for (int i = 0; i < 3; i++) begin
      tick(s, f);
      chk(!s && !f, "R9 SD over threshold", int'({s, f}), 0);
    end
    arm(1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_flag();
    t_zero();
    t_midwrite();
    t_sat();
    t_indep();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule